// File: doc/BRIEF.md
# Store Buffer With Fill Merge

This block sits beside a core's data cache. It absorbs stores aimed at a 16-byte line that the local cache does not hold, so the core keeps running while the line is fetched. Each slot keeps only the bytes that were written, together with a per-byte valid mask. Stores that hit a line already in a slot are folded into that slot. Stores to a new line take a free slot.

For every slot the block sends one coherence request upstream. That request asks for the line's data and asks for every other copy to be invalidated. It has to carry a data fetch, because the bytes the core never wrote must come from the current owner. When the owner's full line comes back, the buffered bytes are laid over it. The returned bytes are kept wherever the mask is clear. The merged line is written into the local cache in the same cycle, and the slot is released.

Slots are allocated, requested and drained strictly oldest first. A full buffer holds off stores to new lines through a ready/valid handshake.

Top module: `sbuf_fill_merge`

## Requirements
- R1: With a free slot, or with a slot already holding the same line, `st_ready` is high and a store with `st_valid` high is taken on that clock edge.
- R2: A slot keeps only written bytes. A later store to the same line overwrites the bytes it enables, adds its enables to the mask, and leaves all other buffered bytes as they were.
- R3: The buffer has `ENTRIES` slots (4 by default). When all are occupied, `st_ready` is low for a store to a line not present. A store to a line already present is still taken.
- R4: Each slot raises exactly one request on `req_valid`/`req_line`, with `req_line` equal to the line address. Requests go out in allocation order. An unaccepted request keeps `req_valid` high and `req_line` unchanged.
- R5: `rsp_ready` is high only when `rsp_line` equals the line of the oldest slot and that slot's request has already been accepted. Otherwise the response is refused and nothing is installed.
- R6: In the cycle a response is taken, `inst_valid` is high and `inst_line` equals `rsp_line`. Byte b of `inst_data` (bits 8b+7..8b) is the buffered byte b when mask bit b is set, and byte b of `rsp_data` when it is clear. This includes bytes stored after the request went out.
- R7: The slot is released on the same edge as its install. Slots drain oldest first, and a freed slot can take a new line on the next store.
- R8: When a response is taken and a store to that same line is offered in the same cycle, `st_ready` is low. The store lands in a fresh slot on a later cycle.
- R9: After reset no slot is occupied: `st_ready` is 1, and `req_valid`, `inst_valid` and `rsp_ready` are 0.
- R10: `st_waddr` is a 32-bit-word address. Bits [1:0] pick the word within the line, and the bits above them form the line address. `st_be` bit k enables byte 4*word+k of the line, taken from `st_wdata` bits 8k+7..8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_waddr | input | ADDR_W-2 | Word address of the store |
| st_wdata | input | 32 | Store data |
| st_be | input | 4 | Byte enables within the word |
| req_valid | output | 1 | Fetch-and-invalidate request pending |
| req_ready | input | 1 | Request accepted |
| req_line | output | ADDR_W-4 | Line address of the request |
| rsp_valid | input | 1 | Full line returned |
| rsp_ready | output | 1 | Returned line matches the oldest requested slot |
| rsp_line | input | ADDR_W-4 | Line address of the returned data |
| rsp_data | input | 128 | Returned line contents |
| inst_valid | output | 1 | Merged line written to the cache |
| inst_line | output | ADDR_W-4 | Line address being written |
| inst_data | output | 128 | Merged line contents |

## Verification
Accepting a store and installing a returned line can happen in the same cycle. The hard case is when both touch the same line: the slot is being freed at the same moment the store would merge into it. The bench sets this up by offering a store to the oldest slot's line in the exact cycle that slot's response is presented. It then expects `st_ready` low, a single install that carries only the earlier bytes, and the retried store to open a new slot that drains later. The checker also watches every cycle in which a response and a store share a line.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;
  localparam int unsigned SB_LINE_BYTES = 16;
  localparam int unsigned SB_WORD_BYTES = 4;
  localparam int unsigned SB_WORDS      = SB_LINE_BYTES / SB_WORD_BYTES;
  localparam int unsigned SB_WSEL_W     = $clog2(SB_WORDS);
  localparam int unsigned SB_OFS_W      = $clog2(SB_LINE_BYTES);
  localparam int unsigned SB_BSEL_W     = $clog2(SB_WORD_BYTES);
  localparam int unsigned SB_LINE_W     = SB_LINE_BYTES * 8;
  localparam int unsigned SB_WORD_W     = SB_WORD_BYTES * 8;

  typedef logic [SB_LINE_W-1:0]     sb_line_t;
  typedef logic [SB_LINE_BYTES-1:0] sb_mask_t;

  // Move word-level byte enables to their byte lanes within the line.
  function automatic sb_mask_t sb_place_mask(input logic [SB_WORD_BYTES-1:0] be,
                                             input logic [SB_WSEL_W-1:0] widx);
    sb_place_mask = sb_mask_t'(be) << (widx * SB_WORD_BYTES);
  endfunction

  // Move a word of store data to its lanes within the line.
  function automatic sb_line_t sb_place_data(input logic [SB_WORD_W-1:0] d,
                                             input logic [SB_WSEL_W-1:0] widx);
    sb_place_data = sb_line_t'(d) << (widx * SB_WORD_W);
  endfunction
endpackage

// File: rtl/sbuf_byte_merge.sv
`timescale 1ns/1ps
// Byte-lane overlay: a lane takes upd when its mask bit is set, else fill.
module sbuf_byte_merge #(
  parameter int unsigned NBYTES = 16
) (
  input  logic [NBYTES*8-1:0] fill,
  input  logic [NBYTES*8-1:0] upd,
  input  logic [NBYTES-1:0]   mask,
  output logic [NBYTES*8-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = mask[b] ? upd[b*8 +: 8] : fill[b*8 +: 8];
  end
endmodule

// File: rtl/sbuf_oldest_pick.sv
`timescale 1ns/1ps
// Finds the first candidate slot at or after head, in ring order.
module sbuf_oldest_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] head,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int unsigned p;
      p = (int'(head) + i) % N;
      if (cand[p]) begin
        found = 1'b1;
        idx   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/sbuf_fill_merge.sv
`timescale 1ns/1ps
module sbuf_fill_merge
  import sbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            st_valid,
  output logic                            st_ready,
  input  logic [ADDR_W-SB_BSEL_W-1:0]     st_waddr,
  input  logic [SB_WORD_W-1:0]            st_wdata,
  input  logic [SB_WORD_BYTES-1:0]        st_be,
  output logic                            req_valid,
  input  logic                            req_ready,
  output logic [ADDR_W-SB_OFS_W-1:0]      req_line,
  input  logic                            rsp_valid,
  output logic                            rsp_ready,
  input  logic [ADDR_W-SB_OFS_W-1:0]      rsp_line,
  input  logic [SB_LINE_W-1:0]            rsp_data,
  output logic                            inst_valid,
  output logic [ADDR_W-SB_OFS_W-1:0]      inst_line,
  output logic [SB_LINE_W-1:0]            inst_data
);
  localparam int unsigned WA_W  = ADDR_W - SB_BSEL_W;
  localparam int unsigned LA_W  = ADDR_W - SB_OFS_W;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
    ring_next = (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Slot state
  logic [ENTRIES-1:0] e_vld, e_iss;
  logic [LA_W-1:0]    e_line [ENTRIES];
  sb_line_t           e_data [ENTRIES];
  sb_mask_t           e_mask [ENTRIES];
  logic [IDX_W-1:0]   head, tail;
  logic [CNT_W-1:0]   count;

  // Named events, also watched by the checker
  logic st_fire, alloc_fire, merge_fire, req_fire, inst_fire, full, rsp_conflict;

  // Store decode
  logic [LA_W-1:0]      st_line;
  logic [SB_WSEL_W-1:0] st_widx;
  assign st_line = st_waddr[WA_W-1:SB_WSEL_W];
  assign st_widx = st_waddr[SB_WSEL_W-1:0];

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (e_vld[i] && (e_line[i] == st_line)) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // Response side: only the oldest, already-requested slot may complete
  assign rsp_ready    = e_vld[head] && e_iss[head] && (rsp_line == e_line[head]);
  assign inst_fire    = rsp_valid && rsp_ready;
  assign rsp_conflict = inst_fire && (st_line == e_line[head]);

  assign full       = (count == FULL_CNT);
  assign st_ready   = !rsp_conflict && (hit_any || !full);
  assign st_fire    = st_valid && st_ready;
  assign merge_fire = st_fire && hit_any;
  assign alloc_fire = st_fire && !hit_any;

  // Store overlay onto the target slot's current contents
  logic [IDX_W-1:0] tgt_idx;
  sb_line_t         base_data, st_ldata, st_new_data;
  sb_mask_t         base_mask, st_mask, st_new_mask;
  assign tgt_idx     = hit_any ? hit_idx : tail;
  assign base_data   = hit_any ? e_data[tgt_idx] : '0;
  assign base_mask   = hit_any ? e_mask[tgt_idx] : '0;
  assign st_mask     = sb_place_mask(st_be, st_widx);
  assign st_ldata    = sb_place_data(st_wdata, st_widx);
  assign st_new_mask = base_mask | st_mask;

  sbuf_byte_merge #(.NBYTES(SB_LINE_BYTES)) u_store_merge (
    .fill(base_data), .upd(st_ldata), .mask(st_mask), .merged(st_new_data)
  );

  // Request issue, oldest unrequested slot first
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  sbuf_oldest_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .cand(e_vld & ~e_iss), .head(head), .found(pick_found), .idx(pick_idx)
  );
  assign req_valid = pick_found;
  assign req_line  = e_line[pick_idx];
  assign req_fire  = req_valid && req_ready;

  // Fill merge: buffered bytes win over returned bytes
  sbuf_byte_merge #(.NBYTES(SB_LINE_BYTES)) u_fill_merge (
    .fill(rsp_data), .upd(e_data[head]), .mask(e_mask[head]), .merged(inst_data)
  );
  assign inst_valid = inst_fire;
  assign inst_line  = e_line[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_iss <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_line[i] <= '0;
        e_data[i] <= '0;
        e_mask[i] <= '0;
      end
    end else begin
      if (st_fire) begin
        e_data[tgt_idx] <= st_new_data;
        e_mask[tgt_idx] <= st_new_mask;
      end
      if (alloc_fire) begin
        e_vld[tail]  <= 1'b1;
        e_iss[tail]  <= 1'b0;
        e_line[tail] <= st_line;
        tail         <= ring_next(tail);
      end
      if (req_fire) e_iss[pick_idx] <= 1'b1;
      if (inst_fire) begin
        e_vld[head] <= 1'b0;
        e_iss[head] <= 1'b0;
        head        <= ring_next(head);
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(inst_fire);
    end
  end
endmodule

// File: rtl/sbuf_fill_merge_chk.sv
`timescale 1ns/1ps
module sbuf_fill_merge_chk #(
  parameter int unsigned WA_W    = 30,
  parameter int unsigned LA_W    = 28,
  parameter int unsigned ENTRIES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_valid,
  input logic            st_ready,
  input logic [WA_W-1:0] st_waddr,
  input logic            req_valid,
  input logic            req_ready,
  input logic [LA_W-1:0] req_line,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [LA_W-1:0] rsp_line,
  input logic            inst_valid,
  input logic [LA_W-1:0] inst_line,
  input logic            alloc_fire,
  input logic [$clog2(ENTRIES+1)-1:0] count
);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> !alloc_fire);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

  p_rsp_has_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |-> (count != '0));

  p_inst_on_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid |-> (rsp_valid && rsp_ready && (inst_line == rsp_line)));

  p_free_same_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && !alloc_fire) |=> (count == $past(count) - 1'b1));

  p_same_line_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && st_valid && (st_waddr[WA_W-1:WA_W-LA_W] == inst_line)) |-> !st_ready);
endmodule

bind sbuf_fill_merge sbuf_fill_merge_chk #(
  .WA_W(WA_W), .LA_W(LA_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_waddr(st_waddr), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_line(rsp_line), .inst_valid(inst_valid), .inst_line(inst_line),
  .alloc_fire(alloc_fire), .count(count)
);

// File: tb/sbuf_fill_merge_tb_top.sv
`timescale 1ns/1ps
module sbuf_fill_merge_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [29:0]  st_waddr = '0;
  logic [31:0]  st_wdata = '0;
  logic [3:0]   st_be = '0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [27:0]  req_line;
  logic         rsp_valid = 1'b0;
  logic         rsp_ready;
  logic [27:0]  rsp_line = '0;
  logic [127:0] rsp_data = '0;
  logic         inst_valid;
  logic [27:0]  inst_line;
  logic [127:0] inst_data;

  always #10 clk = ~clk;

  sbuf_fill_merge dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_waddr(st_waddr), .st_wdata(st_wdata), .st_be(st_be),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line),
    .rsp_data(rsp_data), .inst_valid(inst_valid), .inst_line(inst_line),
    .inst_data(inst_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model: oldest slot at index 0
  logic [27:0]  m_line [4];
  logic [127:0] m_data [4];
  logic [15:0]  m_mask [4];
  int m_n = 0;
  int m_niss = 0;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        drain;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_1000, 32'h1122_3344, 4'b0001, 1'b1},
    '{32'h0000_2004, 32'hAABB_CCDD, 4'b1100, 1'b0},
    '{32'h0000_2004, 32'h5566_7788, 4'b0101, 1'b0},
    '{32'h0000_200C, 32'h99AA_BBCC, 4'b0011, 1'b1},
    '{32'h0000_3000, 32'hDEAD_BEEF, 4'b1111, 1'b0},
    '{32'h0000_4008, 32'h0BAD_F00D, 4'b0100, 1'b0},
    '{32'h0000_5004, 32'hCAFE_0123, 4'b0010, 1'b0},
    '{32'h0000_3000, 32'h0000_0077, 4'b0001, 1'b1}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] fill_of(input logic [27:0] ln);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = ln[7:0] ^ 8'(b * 29 + 7);
    return r;
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    int s;
    s = -1;
    for (int i = 0; i < m_n; i++) if (m_line[i] == a[31:4]) s = i;
    if (s < 0) begin
      s = m_n;
      m_line[s] = a[31:4];
      m_data[s] = '0;
      m_mask[s] = '0;
      m_n++;
    end
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        int bi;
        bi = int'(a[3:2]) * 4 + k;
        m_data[s][bi*8 +: 8] = d[k*8 +: 8];
        m_mask[s][bi] = 1'b1;
      end
    end
  endtask

  task automatic model_pop();
    for (int i = 0; i < 3; i++) begin
      m_line[i] = m_line[i+1];
      m_data[i] = m_data[i+1];
      m_mask[i] = m_mask[i+1];
    end
    m_n--;
    m_niss--;
  endtask

  function automatic logic [127:0] expect_line(input logic [27:0] ln);
    logic [127:0] r;
    r = fill_of(ln);
    for (int b = 0; b < 16; b++) if (m_mask[0][b]) r[b*8 +: 8] = m_data[0][b*8 +: 8];
    return r;
  endfunction

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                       input bit exp_rdy, input string rq);
    @(negedge clk);
    st_valid = 1'b1; st_waddr = a[31:2]; st_wdata = d; st_be = be;
    #1;
    chk(st_ready == exp_rdy, rq, "st_ready", 128'(st_ready), 128'(exp_rdy));
    if (st_ready) model_store(a, d, be);
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic take_req(input logic [27:0] exp_line, input string rq);
    @(negedge clk);
    #1;
    chk(req_valid == 1'b1, rq, "req_valid", 128'(req_valid), 128'(1));
    chk(req_line == exp_line, rq, "req_line", 128'(req_line), 128'(exp_line));
    req_ready = 1'b1;
    @(posedge clk);
    #1 req_ready = 1'b0;
    m_niss++;
  endtask

  task automatic respond(input logic [27:0] ln, input bit exp_rdy, input string rq);
    logic [127:0] exp;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_line = ln; rsp_data = fill_of(ln);
    #1;
    chk(rsp_ready == exp_rdy, rq, "rsp_ready", 128'(rsp_ready), 128'(exp_rdy));
    chk(inst_valid == exp_rdy, rq, "inst_valid", 128'(inst_valid), 128'(exp_rdy));
    if (exp_rdy && inst_valid) begin
      exp = expect_line(ln);
      chk(inst_line == ln, "R6", "inst_line", 128'(inst_line), 128'(ln));
      chk(inst_data == exp, "R6", "inst_data", inst_data, exp);
    end
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    if (exp_rdy) model_pop();
  endtask

  task automatic drain_all(input string rq);
    while (m_n > 0) begin
      if (m_niss == 0) take_req(m_line[0], "R4");
      respond(m_line[0], 1'b1, rq);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(st_ready == 1'b1,   "R9", "st_ready",   128'(st_ready),   128'(1));
    chk(req_valid == 1'b0,  "R9", "req_valid",  128'(req_valid),  128'(0));
    chk(inst_valid == 1'b0, "R9", "inst_valid", 128'(inst_valid), 128'(0));
    chk(rsp_ready == 1'b0,  "R9", "rsp_ready",  128'(rsp_ready),  128'(0));

    // Vector table: placement (R10), same-line folding (R2), FIFO drain (R7)
    for (int v = 0; v < 8; v++) begin
      store(VECS[v].addr, VECS[v].data, VECS[v].be, 1'b1, "R1");
      if (VECS[v].drain) drain_all("R7");
    end

    // Fill all slots, then probe a new line and a present line (R3)
    store(32'h0000_6000, 32'h0102_0304, 4'b1111, 1'b1, "R1");
    store(32'h0000_7000, 32'h1112_1314, 4'b0110, 1'b1, "R1");
    store(32'h0000_8008, 32'h2122_2324, 4'b1001, 1'b1, "R1");
    store(32'h0000_900C, 32'h3132_3334, 4'b1111, 1'b1, "R1");
    store(32'h0000_A000, 32'h4142_4344, 4'b1111, 1'b0, "R3");
    store(32'h0000_7004, 32'h5152_5354, 4'b0011, 1'b1, "R3");

    // Request held while not accepted (R4)
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk(req_valid == 1'b1, "R4", "req_valid hold", 128'(req_valid), 128'(1));
      chk(req_line == 28'h0000_600, "R4", "req_line hold", 128'(req_line), 128'(28'h600));
    end
    take_req(28'h0000_600, "R4");
    respond(28'h0000_700, 1'b0, "R5");   // not the oldest slot
    respond(28'h0000_600, 1'b1, "R6");
    store(32'h0000_A000, 32'h4142_4344, 4'b1111, 1'b1, "R7");  // freed slot reused
    take_req(28'h0000_700, "R4");
    store(32'h0000_7000, 32'h6100_0000, 4'b1000, 1'b1, "R6");  // after request went out

    // Same-line store and install in the same cycle (R8)
    begin
      logic [127:0] exp;
      @(negedge clk);
      rsp_valid = 1'b1; rsp_line = 28'h0000_700; rsp_data = fill_of(28'h0000_700);
      st_valid = 1'b1; st_waddr = 30'h0000_1C02; st_wdata = 32'h7172_7374; st_be = 4'b1111;
      #1;
      exp = expect_line(28'h0000_700);
      chk(st_ready == 1'b0,   "R8", "st_ready",   128'(st_ready),   128'(0));
      chk(inst_valid == 1'b1, "R8", "inst_valid", 128'(inst_valid), 128'(1));
      chk(inst_data == exp,   "R8", "inst_data",  inst_data, exp);
      @(posedge clk);
      #1 rsp_valid = 1'b0; st_valid = 1'b0;
      model_pop();
    end
    store(32'h0000_7008, 32'h7172_7374, 4'b1111, 1'b1, "R8");
    drain_all("R7");

    @(negedge clk);
    #1;
    chk(req_valid == 1'b0, "R4", "no extra request", 128'(req_valid), 128'(0));
    chk(st_ready == 1'b1,  "R1", "st_ready empty",   128'(st_ready),  128'(1));
    chk(rsp_ready == 1'b0, "R5", "rsp_ready empty",  128'(rsp_ready), 128'(0));

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule